// File: doc/BRIEF.md
# UART Register Front End

This block is the software-facing register file of a simple serial port. A 32-bit bus with byte offsets reaches six word registers: control, mode, baud generator, baud divider, channel status and a data port. The block holds the configuration that the framing and baud-timing engines consume. It also owns two 16-entry byte FIFOs: one carries bytes from software to the transmit engine, the other carries bytes from the receive engine back to software.

The control register has no stored enable level that software writes directly. Instead, separate write-one bits set and clear each enable, start and stop the line break, and restart the receive timeout. Two further bits reset the transmit or receive path. Each reset bit stays set for a fixed number of cycles and then clears itself, so software polls until it reads back zero. While a path is in reset, its FIFO is emptied.

Bus reads are combinational: `bus_rdata` is valid in the same cycle as the request. Any side effect of an access, such as a FIFO push or pop, takes effect at the next rising clock edge.

Top module: `uart_regfile`

## Requirements
- R1: Registers sit at byte offsets: control 0x00, mode 0x04, baud generator 0x18, channel status 0x2C, data 0x30 and baud divider 0x34. The mode register reads back its low 10 written bits, the generator its low 16 bits and the divider its low 8 bits. Any other offset reads 0.
- R2: Writing control bit 0 (receive reset) or bit 1 (transmit reset) sets that bit. It reads as 1 in the cycle of the write's edge and for the next 3 cycles, then reads 0. The bit is also driven on `rx_path_rst` / `tx_path_rst`.
- R3: While a path is in reset, its FIFO is emptied. A bus data write that arrives during a transmit reset is dropped, and so is an engine push that arrives during a receive reset.
- R4: Control bit 2 turns receive on and bit 3 turns it off. Bit 4 turns transmit on and bit 5 turns it off. When an on bit and its off bit are written together, the off bit wins. Control reads show receive enable on bit 2 and transmit enable on bit 4.
- R5: Control bit 7 starts a break and bit 8 stops it. When both are written together, the stop wins. Control reads show the break on bit 7. A write with bit 6 set produces a single-cycle `rx_to_restart` pulse.
- R6: Channel status reads: bit 1 is receive FIFO empty, bit 2 is receive FIFO full (16 entries), bit 3 is transmit FIFO empty and bit 4 is transmit FIFO full. All other bits read 0.
- R7: A bus write to the data offset queues its low byte for transmit. If the transmit FIFO is full, the write is dropped.
- R8: A bus read of the data offset returns the oldest received byte and removes it from the FIFO. If the receive FIFO is empty, the read returns 0 and the FIFO stays unchanged.
- R9: After reset, both enables are off, the break is off, both FIFOs are empty and the mode, generator and divider registers read 0.
- R10: The transmit engine sees the oldest byte on `tx_head`, with `tx_ready` high whenever the FIFO is not empty, and consumes the byte with `tx_pop`. A push into a full FIFO is accepted only when a pop happens in the same cycle. Bytes leave each FIFO in the order they entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rx_enable | output | 1 | Receive engine enable |
| tx_enable | output | 1 | Transmit engine enable |
| rx_path_rst | output | 1 | Receive path reset in progress |
| tx_path_rst | output | 1 | Transmit path reset in progress |
| rx_to_restart | output | 1 | One-cycle receive timeout restart |
| brk_active | output | 1 | Drive a line break |
| mode_cfg | output | 10 | Mode register contents |
| baud_gen | output | 16 | Baud generator value |
| baud_div | output | 8 | Baud divider value |
| tx_head | output | 8 | Oldest queued transmit byte |
| tx_ready | output | 1 | Transmit FIFO not empty |
| tx_pop | input | 1 | Transmit engine takes `tx_head` |
| rx_push | input | 1 | Receive engine delivers a byte |
| rx_byte | input | 8 | Received byte |

## Verification
Two activities can hit the same FIFO in one cycle: a software access from the bus and an engine access. On the receive side, a bus data read can pop while the engine pushes. On the transmit side, a bus data write can push while the engine pops. The bench fills each FIFO to 16 entries and then issues both accesses in one cycle. It then checks three things: the read returns the old head, the FIFO still reports full, and draining it yields exactly the expected byte order, with the new byte last. A third collision puts a path reset against traffic that arrives while the reset is in progress. That traffic must vanish, and the FIFO must be empty once the reset bit reads back 0.

// File: rtl/uart_reg_pkg.sv
// Package: register offsets and field positions shared by the register front end.
package uart_reg_pkg;
    localparam int ADDR_W = 6;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_MODE = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_BGEN = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_STS  = 6'h2C;
    localparam logic [ADDR_W-1:0] OFS_DATA = 6'h30;
    localparam logic [ADDR_W-1:0] OFS_BDIV = 6'h34;

    // control bit positions
    localparam int C_RXRST = 0;
    localparam int C_TXRST = 1;
    localparam int C_RXON  = 2;
    localparam int C_RXOFF = 3;
    localparam int C_TXON  = 4;
    localparam int C_TXOFF = 5;
    localparam int C_TOUT  = 6;
    localparam int C_BRKON = 7;
    localparam int C_BRKOFF = 8;

    // status bit positions
    localparam int S_RXEMP = 1;
    localparam int S_RXFUL = 2;
    localparam int S_TXEMP = 3;
    localparam int S_TXFUL = 4;
endpackage

// File: rtl/uart_byte_fifo.sv
// Synchronous FIFO with flush. Assumes DEPTH is a power of two.
// A push into a full FIFO is accepted only when a pop happens in the same cycle.
// Flush has priority over push and pop.
module uart_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;
    logic          do_pop, do_push;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rd_ptr];

    // storage write
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= din;
    end

    // pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)) else $error("fifo overflow"); // R7
    AST_EMPTY_POP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty) else $error("pop on empty changed fifo"); // R8
endmodule

// File: rtl/uart_rst_timer.sv
// Self-clearing reset stretcher: once started, busy stays high for CYC cycles.
// Assumes CYC >= 1. A new start reloads the count.
module uart_rst_timer #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYC + 1);
    logic [CW-1:0] cnt;

    assign busy = (cnt != '0);

    // reload on start, count down to zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (start) cnt <= CW'(CYC);
        else if (busy)  cnt <= cnt - 1'b1;
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy) else $error("reset not raised"); // R2
endmodule

// File: rtl/uart_regfile.sv
// UART register front end: bus decode, set/clear control bits, self-clearing
// path resets, configuration registers and two byte FIFOs toward the engines.
// Assumes aligned word accesses; bus_rdata is combinational in the access cycle.
module uart_regfile
    import uart_reg_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int RST_CYC    = 4,
    parameter int MODE_W     = 10,
    parameter int GEN_W      = 16,
    parameter int DIV_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              rx_enable,
    output logic              tx_enable,
    output logic              rx_path_rst,
    output logic              tx_path_rst,
    output logic              rx_to_restart,
    output logic              brk_active,
    output logic [MODE_W-1:0] mode_cfg,
    output logic [GEN_W-1:0]  baud_gen,
    output logic [DIV_W-1:0]  baud_div,
    output logic [7:0]        tx_head,
    output logic              tx_ready,
    input  logic              tx_pop,
    input  logic              rx_push,
    input  logic [7:0]        rx_byte
);
    logic wr_ctrl, wr_data, rd_data;
    logic rx_empty, rx_full, tx_empty, tx_full;
    logic [7:0] rx_head;

    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
    assign wr_data = bus_sel && bus_wr && (bus_addr == OFS_DATA);
    assign rd_data = bus_sel && !bus_wr && (bus_addr == OFS_DATA);

    // enable, break and timeout-restart control; the clearing bit wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_enable     <= 1'b0;
            tx_enable     <= 1'b0;
            brk_active    <= 1'b0;
            rx_to_restart <= 1'b0;
        end else begin
            rx_to_restart <= wr_ctrl && bus_wdata[C_TOUT];
            if (wr_ctrl) begin
                if (bus_wdata[C_RXOFF])      rx_enable <= 1'b0;
                else if (bus_wdata[C_RXON])  rx_enable <= 1'b1;
                if (bus_wdata[C_TXOFF])      tx_enable <= 1'b0;
                else if (bus_wdata[C_TXON])  tx_enable <= 1'b1;
                if (bus_wdata[C_BRKOFF])     brk_active <= 1'b0;
                else if (bus_wdata[C_BRKON]) brk_active <= 1'b1;
            end
        end
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_cfg <= '0;
            baud_gen <= '0;
            baud_div <= '0;
        end else if (bus_sel && bus_wr) begin
            if (bus_addr == OFS_MODE) mode_cfg <= bus_wdata[MODE_W-1:0];
            if (bus_addr == OFS_BGEN) baud_gen <= bus_wdata[GEN_W-1:0];
            if (bus_addr == OFS_BDIV) baud_div <= bus_wdata[DIV_W-1:0];
        end
    end

    uart_rst_timer #(.CYC(RST_CYC)) u_rx_rst (
        .clk(clk), .rst_n(rst_n),
        .start(wr_ctrl && bus_wdata[C_RXRST]), .busy(rx_path_rst));

    uart_rst_timer #(.CYC(RST_CYC)) u_tx_rst (
        .clk(clk), .rst_n(rst_n),
        .start(wr_ctrl && bus_wdata[C_TXRST]), .busy(tx_path_rst));

    uart_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(tx_path_rst),
        .push(wr_data && !tx_path_rst), .din(bus_wdata[7:0]),
        .pop(tx_pop), .dout(tx_head), .empty(tx_empty), .full(tx_full));

    uart_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(rx_path_rst),
        .push(rx_push && !rx_path_rst), .din(rx_byte),
        .pop(rd_data), .dout(rx_head), .empty(rx_empty), .full(rx_full));

    assign tx_ready = !tx_empty;

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (bus_addr)
                OFS_CTRL: begin
                    bus_rdata[C_RXRST] = rx_path_rst;
                    bus_rdata[C_TXRST] = tx_path_rst;
                    bus_rdata[C_RXON]  = rx_enable;
                    bus_rdata[C_TXON]  = tx_enable;
                    bus_rdata[C_BRKON] = brk_active;
                end
                OFS_MODE: bus_rdata[MODE_W-1:0] = mode_cfg;
                OFS_BGEN: bus_rdata[GEN_W-1:0]  = baud_gen;
                OFS_BDIV: bus_rdata[DIV_W-1:0]  = baud_div;
                OFS_STS: begin
                    bus_rdata[S_RXEMP] = rx_empty;
                    bus_rdata[S_RXFUL] = rx_full;
                    bus_rdata[S_TXEMP] = tx_empty;
                    bus_rdata[S_TXFUL] = tx_full;
                end
                OFS_DATA: bus_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
                default:  bus_rdata = '0;
            endcase
        end
    end

    AST_RX_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[C_RXOFF]) |=> !rx_enable) else $error("rx off lost"); // R4
    AST_TX_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[C_TXOFF]) |=> !tx_enable) else $error("tx off lost"); // R4
    AST_BRK_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[C_BRKOFF]) |=> !brk_active) else $error("break stop lost"); // R5
    AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_path_rst |=> rx_empty) else $error("rx not flushed"); // R3
    AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_path_rst |=> tx_empty) else $error("tx not flushed"); // R3
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && rx_empty) |-> (bus_rdata == 32'h0)) else $error("empty read nonzero"); // R8
    AST_TOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_to_restart && !(wr_ctrl && bus_wdata[C_TOUT])) |=> !rx_to_restart)
        else $error("timeout pulse stuck"); // R5
endmodule

// File: tb/sim_uart_regfile.sv
module sim_uart_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_enable, tx_enable, rx_path_rst, tx_path_rst, rx_to_restart, brk_active;
    logic [9:0]  mode_cfg;
    logic [15:0] baud_gen;
    logic [7:0]  baud_div, tx_head, rx_byte = '0;
    logic        tx_ready, tx_pop = 1'b0, rx_push = 1'b0;

    int checks = 0, errors = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    logic [31:0] rd;
    logic [7:0]  th;

    always #4 clk = ~clk;

    uart_regfile u0 (.*);

    function automatic logic [31:0] exp_sts();
        logic [31:0] s = '0;
        s[1] = (rxq.size() == 0);
        s[2] = (rxq.size() == 16);
        s[3] = (txq.size() == 0);
        s[4] = (txq.size() == 16);
        return s;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock of stimulus; samples combinational outputs before the edge
    task automatic cyc(input logic s, input logic w, input logic [5:0] a, input logic [31:0] d,
                       input logic tp, input logic rp, input logic [7:0] rb,
                       output logic [31:0] r, output logic [7:0] h);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        tx_pop = tp; rx_push = rp; rx_byte = rb;
        #1;
        r = bus_rdata; h = tx_head;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0; tx_pop = 0; rx_push = 0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        logic [31:0] r; logic [7:0] h;
        cyc(1, 1, a, d, 0, 0, 0, r, h);
    endtask

    task automatic rdr(input logic [5:0] a, output logic [31:0] r);
        logic [7:0] h;
        cyc(1, 0, a, 0, 0, 0, 0, r, h);
    endtask

    task automatic idle();
        logic [31:0] r; logic [7:0] h;
        cyc(0, 0, 0, 0, 0, 0, 0, r, h);
    endtask

    // bus write to data with model update (R7)
    task automatic tx_wr(input logic [7:0] b);
        wr(6'h30, {24'h0, b});
        if (txq.size() < 16) txq.push_back(b);
    endtask

    // engine pop with order check (R10)
    task automatic tx_take();
        logic [31:0] r; logic [7:0] h;
        cyc(0, 0, 0, 0, 1, 0, 0, r, h);
        chk("R10 tx_head order", {24'h0, h}, {24'h0, txq.pop_front()});
    endtask

    task automatic rx_give(input logic [7:0] b);
        logic [31:0] r; logic [7:0] h;
        cyc(0, 0, 0, 0, 0, 1, b, r, h);
        if (rxq.size() < 16) rxq.push_back(b);
    endtask

    task automatic rx_read();
        logic [31:0] exp;
        exp = (rxq.size() == 0) ? 32'h0 : {24'h0, rxq.pop_front()};
        rdr(6'h30, rd);
        chk("R8 data read", rd, exp);
    endtask

    initial begin
        #(8 * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R9 reset state
        rdr(6'h00, rd); chk("R9 ctrl after reset", rd, 32'h0);
        rdr(6'h2C, rd); chk("R9 status after reset", rd, 32'h0A);
        rdr(6'h04, rd); chk("R9 mode after reset", rd, 32'h0);
        chk("R9 tx_ready after reset", {31'h0, tx_ready}, 32'h0);

        // R1 register readback
        v = $urandom; wr(6'h04, v); rdr(6'h04, rd); chk("R1 mode readback", rd, v & 32'h3FF);
        v = $urandom; wr(6'h18, v); rdr(6'h18, rd); chk("R1 gen readback", rd, v & 32'hFFFF);
        chk("R1 gen port", {16'h0, baud_gen}, v & 32'hFFFF);
        v = $urandom; wr(6'h34, v); rdr(6'h34, rd); chk("R1 div readback", rd, v & 32'hFF);
        rdr(6'h08, rd); chk("R1 unmapped offset", rd, 32'h0);

        // R4 enables
        wr(6'h00, 32'h14); rdr(6'h00, rd); chk("R4 both on", rd, 32'h14);
        wr(6'h00, 32'h0C); rdr(6'h00, rd); chk("R4 rx off wins", rd, 32'h10);
        chk("R4 rx_enable port", {31'h0, rx_enable}, 32'h0);
        wr(6'h00, 32'h30); rdr(6'h00, rd); chk("R4 tx off wins", rd, 32'h0);

        // R5 break and timeout restart
        wr(6'h00, 32'h80); chk("R5 break on", {31'h0, brk_active}, 32'h1);
        wr(6'h00, 32'h180); rdr(6'h00, rd); chk("R5 stop wins", rd, 32'h0);
        wr(6'h00, 32'h40); chk("R5 timeout pulse", {31'h0, rx_to_restart}, 32'h1);
        idle(); chk("R5 timeout pulse single", {31'h0, rx_to_restart}, 32'h0);

        // R7 R8 R10 random traffic
        for (int round = 0; round < 4; round++) begin
            int n;
            n = $urandom_range(0, 20);
            for (int i = 0; i < n; i++) tx_wr(8'($urandom));
            rdr(6'h2C, rd); chk("R6 status after tx fill", rd, exp_sts());
            chk("R10 tx_ready", {31'h0, tx_ready}, {31'h0, txq.size() != 0});
            while (txq.size() != 0) tx_take();
            n = $urandom_range(0, 20);
            for (int i = 0; i < n; i++) rx_give(8'($urandom));
            rdr(6'h2C, rd); chk("R6 status after rx fill", rd, exp_sts());
            while (rxq.size() != 0) rx_read();
            rx_read();
            rdr(6'h2C, rd); chk("R8 empty read leaves fifo empty", rd, exp_sts());
        end

        // Directed: full fifos with simultaneous bus and engine access
        for (int i = 0; i < 17; i++) tx_wr(8'(i + 8'h40));
        rdr(6'h2C, rd); chk("R6 tx full", rd, exp_sts());
        begin
            logic [31:0] r; logic [7:0] h;
            cyc(1, 1, 6'h30, 32'hEE, 1, 0, 0, r, h);
            chk("R10 pop head while push", {24'h0, h}, {24'h0, txq.pop_front()});
            txq.push_back(8'hEE);
        end
        rdr(6'h2C, rd); chk("R10 tx still full", rd, exp_sts());
        while (txq.size() != 0) tx_take();

        for (int i = 0; i < 16; i++) rx_give(8'(i + 8'h80));
        rx_give(8'h11);
        rdr(6'h2C, rd); chk("R6 rx full", rd, exp_sts());
        begin
            logic [31:0] r; logic [7:0] h;
            cyc(1, 0, 6'h30, 0, 0, 1, 8'hAB, r, h);
            chk("R10 read head while push", r, {24'h0, rxq.pop_front()});
            rxq.push_back(8'hAB);
        end
        rdr(6'h2C, rd); chk("R10 rx still full", rd, exp_sts());
        while (rxq.size() != 0) rx_read();

        // R2 R3 path reset
        tx_wr(8'h01); tx_wr(8'h02); rx_give(8'h03);
        wr(6'h00, 32'h03);
        rdr(6'h00, rd); chk("R2 reset bits set", rd, 32'h03);
        wr(6'h30, 32'h55);
        rx_give(8'h66);
        rdr(6'h00, rd); chk("R2 reset bits still set", rd, 32'h03);
        rdr(6'h00, rd); chk("R2 reset bits cleared", rd, 32'h0);
        txq.delete(); rxq.delete();
        rdr(6'h2C, rd); chk("R3 fifos flushed", rd, 32'h0A);
        chk("R3 tx_ready after flush", {31'h0, tx_ready}, 32'h0);
        rx_read();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule